// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide register front end of an eight-line interrupt controller. A host writes and reads bytes at two addresses, selected by a one-bit address input. Writes to address 0 are sorted into three kinds of command by bits 4 and 3: an initialisation start, a status/mode command, or an ordering command. Writes to address 1 feed the initialisation sequence while it runs, and load the interrupt mask once it has finished. The block turns these bytes into mode bits and one-cycle control pulses. A separate priority resolver, outside this block, uses those pulses to retire in-service lines, rotate priority and clear its own state.

Reads return one of three registers: the request register, the in-service register, or the mask. The request and in-service registers are supplied by the resolver. A read can also return a poll result. While poll is armed, the next read acknowledges the resolver's current winning line and returns it with bit 7 set. A small trigger-mode register sits beside the command path. It has its own write strobe, and a fixed per-instance mask limits which of its bits can be written.

All outputs are registered. Each result appears in the cycle that follows the strobe that caused it, and every control pulse lasts exactly one cycle.

Top module: `pic_cmd_if`

## Requirements
- R1: After reset, rdData, maskReg, vectorBase, trigMode and every mode bit read 0, and no pulse output is high.
- R2: A write to address 0 with bit 4 set is an initialisation start.
  - It raises clrAllPulse for one cycle.
  - It clears maskReg, vectorBase, nestedMode, autoEoi, rotateAutoEoi and specialMask.
  - It selects the request register for reads and disarms poll.
  - It captures bit 1 as singleMode and bit 0 as "mode word needed".
  - It ignores bit 3 (level-sensitive request).
  - It restarts the sequence at the vector step whatever step was in progress.
- R3: The first address-1 write after an initialisation start sets vectorBase to the written byte with bits 2:0 forced to 0. It leaves maskReg unchanged.
- R4: The sequence steps in a fixed order.
  - After the vector step, the next address-1 write is a cascade word unless singleMode is set. A cascade word is discarded and maskReg stays unchanged.
  - After the cascade step, or straight after the vector step in single mode, the next address-1 write is the mode word if one was requested. Otherwise the block returns to normal operation.
- R5: In the mode word, bit 4 sets nestedMode and bit 1 sets autoEoi.
- R6: In normal operation an address-1 write loads maskReg. maskReg changes on no other write except R2. A plain read of address 1 returns maskReg.
- R7: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a status command. When its bit 1 is set, bit 0 selects what a plain read of address 0 returns: isrReg (1) or reqReg (0). When bit 1 is clear, the selection is kept.
- R8: In a status command, bit 6 = 1 loads specialMask from bit 5. When bit 6 = 0, specialMask is kept.
- R9: A write to address 0 with bits 4 and 3 both 0 is an ordering command, selected by bits 7:5. Code 4 sets rotateAutoEoi and code 0 clears it. Code 2 raises no pulse and changes no state.
- R10: Ordering codes 1, 5, 3 and 7 raise eoiPulse for one cycle, with these qualifiers:
  - code 1: eoiSpecific = 0, eoiRotate = 0;
  - code 5: eoiSpecific = 0, eoiRotate = 1;
  - code 3: eoiSpecific = 1, eoiRotate = 0;
  - code 7: eoiSpecific = 1, eoiRotate = 1.
  For the specific codes, eoiLine equals bits 2:0. No write raises more than one of clrAllPulse, eoiPulse and prioPulse.
- R11: Ordering code 6 raises prioPulse for one cycle, with prioLine equal to bits 2:0. It raises no eoiPulse.
- R12: Poll works as follows.
  - A status command with bit 2 set arms poll.
  - While poll is armed, the next read from either address is a poll read. If pollValid is high, that read returns 0x80 OR pollLine and raises ackPulse for one cycle with ackLine = pollLine. If pollValid is low, it returns 0 and raises no ackPulse.
  - Poll is then disarmed, so the read after it is a plain read.
- R13: A trigWrEn cycle sets trigMode to trigData AND TRIG_MASK. trigMode changes at no other time; the command interface, including an initialisation start, never touches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Byte read strobe; ignored in a cycle with wrEn |
| addrSel | input | 1 | Address bit: 0 = command port, 1 = data port |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, valid the cycle after rdEn |
| reqReg | input | 8 | Request register from the resolver |
| isrReg | input | 8 | In-service register from the resolver |
| pollValid | input | 1 | Resolver has a qualifying line |
| pollLine | input | 3 | Resolver's winning line |
| trigWrEn | input | 1 | Trigger-mode register write strobe |
| trigData | input | 8 | Trigger-mode write byte |
| trigMode | output | 8 | Trigger-mode register |
| maskReg | output | 8 | Interrupt mask |
| vectorBase | output | 8 | Vector base, bits 2:0 zero |
| singleMode | output | 1 | Single-controller mode captured at initialisation |
| nestedMode | output | 1 | Special fully nested mode |
| autoEoi | output | 1 | Automatic end-of-interrupt mode |
| rotateAutoEoi | output | 1 | Rotate priority on automatic end-of-interrupt |
| specialMask | output | 1 | Special mask mode |
| clrAllPulse | output | 1 | One-cycle pulse: resolver clears its state |
| eoiPulse | output | 1 | One-cycle end-of-interrupt pulse |
| eoiSpecific | output | 1 | Qualifier: EOI names eoiLine |
| eoiRotate | output | 1 | Qualifier: EOI also rotates priority |
| eoiLine | output | 3 | Line for a specific EOI |
| prioPulse | output | 1 | One-cycle set-priority pulse |
| prioLine | output | 3 | Line given lowest priority |
| ackPulse | output | 1 | One-cycle acknowledge from a poll read |
| ackLine | output | 3 | Acknowledged line |

## Verification
A wrong initialisation step shows on the first address-1 write after the step goes wrong. That byte lands in vectorBase, the mode bits or maskReg instead of the register the sequence calls for, and the error is visible one cycle later. So each path through the sequence is followed by one write and a check of all three destinations. A stale poll flag shows on the read that follows the poll read: rdData carries bit 7 and a spurious ackPulse instead of the selected register. That read is checked directly after every poll read.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int LINES  = 8;
  localparam int LINE_W = $clog2(LINES);
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,
    STEP_VEC  = 2'd1,
    STEP_CAS  = 2'd2,
    STEP_MODE = 2'd3
  } initStep_e;

  typedef enum logic [2:0] {
    OP_ROT_CLR = 3'd0,
    OP_EOI     = 3'd1,
    OP_NOP     = 3'd2,
    OP_SEOI    = 3'd3,
    OP_ROT_SET = 3'd4,
    OP_REOI    = 3'd5,
    OP_PRIO    = 3'd6,
    OP_RSEOI   = 3'd7
  } orderOp_e;

  typedef struct packed {
    logic initWord;
    logic vecLoad;
    logic modeLoad;
    logic maskLoad;
    logic statusCmd;
    logic orderCmd;
    logic pollRead;
    logic plainRead;
  } cmdStrobe_t;
endpackage

// File: rtl/pic_cmd_ctrl.sv
module pic_cmd_ctrl
  import pic_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       addrSel,
  input  logic [4:0] cmdBits,
  output cmdStrobe_t strobe,
  output logic       singleMode
);
  initStep_e step;
  logic      needMode;
  logic      pollArmed;
  logic      isInit, isStatus, isOrder, dataWr, readCycle;

  always_comb begin
    isInit    = wrEn && !addrSel && cmdBits[4];
    isStatus  = wrEn && !addrSel && !cmdBits[4] && cmdBits[3];
    isOrder   = wrEn && !addrSel && !cmdBits[4] && !cmdBits[3];
    dataWr    = wrEn && addrSel;
    readCycle = rdEn && !wrEn;

    strobe.initWord  = isInit;
    strobe.vecLoad   = dataWr && (step == STEP_VEC);
    strobe.modeLoad  = dataWr && (step == STEP_MODE);
    strobe.maskLoad  = dataWr && (step == STEP_RUN);
    strobe.statusCmd = isStatus;
    strobe.orderCmd  = isOrder;
    strobe.pollRead  = readCycle && pollArmed;
    strobe.plainRead = readCycle && !pollArmed;
  end

  // Initialisation sequencer; bit 3 of the start word is ignored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= STEP_RUN;
      needMode   <= 1'b0;
      singleMode <= 1'b0;
    end else if (isInit) begin
      step       <= STEP_VEC;
      needMode   <= cmdBits[0];
      singleMode <= cmdBits[1];
    end else if (dataWr) begin
      case (step)
        STEP_VEC:  step <= singleMode ? (needMode ? STEP_MODE : STEP_RUN) : STEP_CAS;
        STEP_CAS:  step <= needMode ? STEP_MODE : STEP_RUN;
        STEP_MODE: step <= STEP_RUN;
        default:   step <= STEP_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pollArmed <= 1'b0;
    else if (isInit)                 pollArmed <= 1'b0;
    else if (isStatus && cmdBits[2]) pollArmed <= 1'b1;
    else if (strobe.pollRead)        pollArmed <= 1'b0;
  end
endmodule

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs
  import pic_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TRIG_MASK = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmdStrobe_t        strobe,
  input  logic              addrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] reqReg,
  input  logic [BYTE_W-1:0] isrReg,
  input  logic              pollValid,
  input  logic [LINE_W-1:0] pollLine,
  input  logic              trigWrEn,
  input  logic [BYTE_W-1:0] trigData,
  output logic [BYTE_W-1:0] trigMode,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] maskReg,
  output logic [BYTE_W-1:0] vectorBase,
  output logic              nestedMode,
  output logic              autoEoi,
  output logic              rotateAutoEoi,
  output logic              specialMask,
  output logic              clrAllPulse,
  output logic              eoiPulse,
  output logic              eoiSpecific,
  output logic              eoiRotate,
  output logic [LINE_W-1:0] eoiLine,
  output logic              prioPulse,
  output logic [LINE_W-1:0] prioLine,
  output logic              ackPulse,
  output logic [LINE_W-1:0] ackLine
);
  localparam int VEC_LSB = LINE_W;
  localparam int PAD_W   = BYTE_W - 1 - LINE_W;

  logic     readIsr;
  orderOp_e op;

  assign op = orderOp_e'(wrData[7:5]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg       <= '0;
      vectorBase    <= '0;
      nestedMode    <= 1'b0;
      autoEoi       <= 1'b0;
      rotateAutoEoi <= 1'b0;
      specialMask   <= 1'b0;
      readIsr       <= 1'b0;
      clrAllPulse   <= 1'b0;
      eoiPulse      <= 1'b0;
      eoiSpecific   <= 1'b0;
      eoiRotate     <= 1'b0;
      eoiLine       <= '0;
      prioPulse     <= 1'b0;
      prioLine      <= '0;
    end else begin
      clrAllPulse <= 1'b0;
      eoiPulse    <= 1'b0;
      eoiSpecific <= 1'b0;
      eoiRotate   <= 1'b0;
      prioPulse   <= 1'b0;
      if (strobe.initWord) begin
        maskReg       <= '0;
        vectorBase    <= '0;
        nestedMode    <= 1'b0;
        autoEoi       <= 1'b0;
        rotateAutoEoi <= 1'b0;
        specialMask   <= 1'b0;
        readIsr       <= 1'b0;
        clrAllPulse   <= 1'b1;
      end
      if (strobe.vecLoad)
        vectorBase <= {wrData[BYTE_W-1:VEC_LSB], {VEC_LSB{1'b0}}};
      if (strobe.modeLoad) begin
        nestedMode <= wrData[4];
        autoEoi    <= wrData[1];
      end
      if (strobe.maskLoad)
        maskReg <= wrData;
      if (strobe.statusCmd) begin
        if (wrData[1]) readIsr     <= wrData[0];
        if (wrData[6]) specialMask <= wrData[5];
      end
      if (strobe.orderCmd) begin
        case (op)
          OP_ROT_CLR: rotateAutoEoi <= 1'b0;
          OP_ROT_SET: rotateAutoEoi <= 1'b1;
          OP_EOI:     eoiPulse <= 1'b1;
          OP_REOI: begin
            eoiPulse  <= 1'b1;
            eoiRotate <= 1'b1;
          end
          OP_SEOI: begin
            eoiPulse    <= 1'b1;
            eoiSpecific <= 1'b1;
            eoiLine     <= wrData[LINE_W-1:0];
          end
          OP_RSEOI: begin
            eoiPulse    <= 1'b1;
            eoiSpecific <= 1'b1;
            eoiRotate   <= 1'b1;
            eoiLine     <= wrData[LINE_W-1:0];
          end
          OP_PRIO: begin
            prioPulse <= 1'b1;
            prioLine  <= wrData[LINE_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  // Read path: poll read doubles as acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData   <= '0;
      ackPulse <= 1'b0;
      ackLine  <= '0;
    end else begin
      ackPulse <= 1'b0;
      if (strobe.pollRead) begin
        if (pollValid) begin
          rdData   <= {1'b1, {PAD_W{1'b0}}, pollLine};
          ackPulse <= 1'b1;
          ackLine  <= pollLine;
        end else begin
          rdData <= '0;
        end
      end else if (strobe.plainRead) begin
        rdData <= addrSel ? maskReg : (readIsr ? isrReg : reqReg);
      end
    end
  end

  // Trigger-mode register: only bits enabled in TRIG_MASK get a flop.
  for (genvar b = 0; b < BYTE_W; b++) begin : g_trig
    if (TRIG_MASK[b]) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        trigMode[b] <= 1'b0;
        else if (trigWrEn) trigMode[b] <= trigData[b];
      end
    end else begin : g_tie
      logic unusedBit;
      assign unusedBit   = trigData[b];
      assign trigMode[b] = 1'b0;
    end
  end
endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       addrSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [7:0] reqReg,
  input  logic [7:0] isrReg,
  input  logic       pollValid,
  input  logic [2:0] pollLine,
  input  logic       trigWrEn,
  input  logic [7:0] trigData,
  output logic [7:0] trigMode,
  output logic [7:0] maskReg,
  output logic [7:0] vectorBase,
  output logic       singleMode,
  output logic       nestedMode,
  output logic       autoEoi,
  output logic       rotateAutoEoi,
  output logic       specialMask,
  output logic       clrAllPulse,
  output logic       eoiPulse,
  output logic       eoiSpecific,
  output logic       eoiRotate,
  output logic [2:0] eoiLine,
  output logic       prioPulse,
  output logic [2:0] prioLine,
  output logic       ackPulse,
  output logic [2:0] ackLine
);
  cmdStrobe_t strobe;

  pic_cmd_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .addrSel    (addrSel),
    .cmdBits    (wrData[4:0]),
    .strobe     (strobe),
    .singleMode (singleMode)
  );

  pic_cmd_regs #(.TRIG_MASK(TRIG_MASK)) regs_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .addrSel       (addrSel),
    .wrData        (wrData),
    .reqReg        (reqReg),
    .isrReg        (isrReg),
    .pollValid     (pollValid),
    .pollLine      (pollLine),
    .trigWrEn      (trigWrEn),
    .trigData      (trigData),
    .trigMode      (trigMode),
    .rdData        (rdData),
    .maskReg       (maskReg),
    .vectorBase    (vectorBase),
    .nestedMode    (nestedMode),
    .autoEoi       (autoEoi),
    .rotateAutoEoi (rotateAutoEoi),
    .specialMask   (specialMask),
    .clrAllPulse   (clrAllPulse),
    .eoiPulse      (eoiPulse),
    .eoiSpecific   (eoiSpecific),
    .eoiRotate     (eoiRotate),
    .eoiLine       (eoiLine),
    .prioPulse     (prioPulse),
    .prioLine      (prioLine),
    .ackPulse      (ackPulse),
    .ackLine       (ackLine)
  );
endmodule

// File: rtl/pic_cmd_if_chk.sv
module pic_cmd_if_chk #(
  parameter logic [7:0] TRIG_MASK = 8'hF8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wrEn,
  input logic       rdEn,
  input logic       addrSel,
  input logic       initBit,
  input logic       trigWrEn,
  input logic [7:0] trigData,
  input logic [7:0] trigMode,
  input logic [7:0] maskReg,
  input logic [7:0] rdData,
  input logic       clrAllPulse,
  input logic       eoiPulse,
  input logic       prioPulse,
  input logic       ackPulse,
  input logic [2:0] ackLine
);
  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !addrSel && initBit) |=> (clrAllPulse && maskReg == 8'h00));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(maskReg));

  // R10
  one_cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clrAllPulse, eoiPulse, prioPulse}));

  // R12
  poll_ack_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackPulse |-> (rdData == {5'b10000, ackLine}));

  // R12
  ack_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackPulse |-> $past(rdEn && !wrEn));

  // R13
  trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigWrEn |=> (trigMode == ($past(trigData) & TRIG_MASK)));

  // R13
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trigWrEn |=> $stable(trigMode));
endmodule

bind pic_cmd_if pic_cmd_if_chk #(.TRIG_MASK(TRIG_MASK)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wrEn        (wrEn),
  .rdEn        (rdEn),
  .addrSel     (addrSel),
  .initBit     (wrData[4]),
  .trigWrEn    (trigWrEn),
  .trigData    (trigData),
  .trigMode    (trigMode),
  .maskReg     (maskReg),
  .rdData      (rdData),
  .clrAllPulse (clrAllPulse),
  .eoiPulse    (eoiPulse),
  .prioPulse   (prioPulse),
  .ackPulse    (ackPulse),
  .ackLine     (ackLine)
);

// File: tb/pic_cmd_if_tb_top.sv
`timescale 1ns/1ps
module pic_cmd_if_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, addrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] reqReg = '0, isrReg = '0;
  logic       pollValid = 1'b0;
  logic [2:0] pollLine = '0;
  logic       trigWrEn = 1'b0;
  logic [7:0] trigData = '0;
  logic [7:0] rdData, trigMode, maskReg, vectorBase;
  logic       singleMode, nestedMode, autoEoi, rotateAutoEoi, specialMask;
  logic       clrAllPulse, eoiPulse, eoiSpecific, eoiRotate, prioPulse, ackPulse;
  logic [2:0] eoiLine, prioLine, ackLine;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pic_cmd_if #(.TRIG_MASK(8'hF8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addrSel(addrSel),
    .wrData(wrData), .rdData(rdData), .reqReg(reqReg), .isrReg(isrReg),
    .pollValid(pollValid), .pollLine(pollLine), .trigWrEn(trigWrEn),
    .trigData(trigData), .trigMode(trigMode), .maskReg(maskReg),
    .vectorBase(vectorBase), .singleMode(singleMode), .nestedMode(nestedMode),
    .autoEoi(autoEoi), .rotateAutoEoi(rotateAutoEoi), .specialMask(specialMask),
    .clrAllPulse(clrAllPulse), .eoiPulse(eoiPulse), .eoiSpecific(eoiSpecific),
    .eoiRotate(eoiRotate), .eoiLine(eoiLine), .prioPulse(prioPulse),
    .prioLine(prioLine), .ackPulse(ackPulse), .ackLine(ackLine)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive one write; returns in the cycle where its results are visible.
  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addrSel = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic a);
    @(negedge clk);
    rdEn = 1'b1; addrSel = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic logic [7:0] pulses();
    return {2'b0, clrAllPulse, eoiPulse, eoiSpecific, eoiRotate, prioPulse, ackPulse};
  endfunction

  task automatic t_reset();
    chk("R1 rdData", rdData, 8'h00);
    chk("R1 mask", maskReg, 8'h00);
    chk("R1 vector", vectorBase, 8'h00);
    chk("R1 trig", trigMode, 8'h00);
    chk("R1 modes", {3'b0, singleMode, nestedMode, autoEoi, rotateAutoEoi, specialMask}, 8'h00);
    chk("R1 pulses", pulses(), 8'h00);
  endtask

  task automatic t_init_single();
    wr(1'b0, 8'h12);
    chk("R2 clrAll pulse", pulses(), 8'h20);
    chk("R2 single", {7'b0, singleMode}, 8'h01);
    wr(1'b1, 8'hA5);
    chk("R3 vector", vectorBase, 8'hA0);
    chk("R3 mask kept", maskReg, 8'h00);
    wr(1'b1, 8'h3C);
    chk("R4 single no mode word -> run", maskReg, 8'h3C);
    rd(1'b1);
    chk("R6 read mask", rdData, 8'h3C);
  endtask

  task automatic t_init_full();
    wr(1'b0, 8'h11);
    chk("R2 mask cleared", maskReg, 8'h00);
    chk("R2 single clear", {7'b0, singleMode}, 8'h00);
    wr(1'b1, 8'h48);
    chk("R3 vector", vectorBase, 8'h48);
    wr(1'b1, 8'hFF);
    chk("R4 cascade word discarded", maskReg, 8'h00);
    wr(1'b1, 8'h12);
    chk("R5 mode word", {6'b0, nestedMode, autoEoi}, 8'h03);
    chk("R4 mode word not mask", maskReg, 8'h00);
    wr(1'b1, 8'h55);
    chk("R6 mask load", maskReg, 8'h55);
  endtask

  task automatic t_init_level();
    wr(1'b0, 8'h1B);
    chk("R2 level bit ignored, clear", pulses(), 8'h20);
    chk("R2 modes cleared", {6'b0, nestedMode, autoEoi}, 8'h00);
    wr(1'b1, 8'h0F);
    chk("R3 vector low bits zero", vectorBase, 8'h08);
    wr(1'b1, 8'h02);
    chk("R5 autoEoi only", {6'b0, nestedMode, autoEoi}, 8'h01);
    wr(1'b1, 8'h0F);
    chk("R6 mask after single+mode", maskReg, 8'h0F);
  endtask

  task automatic t_restart();
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h20);
    chk("R3 vector", vectorBase, 8'h20);
    wr(1'b0, 8'h13);
    chk("R2 restart clears vector", vectorBase, 8'h00);
    wr(1'b1, 8'h30);
    chk("R2 restart back to vector step", vectorBase, 8'h30);
    wr(1'b1, 8'h10);
    chk("R5 nested only", {6'b0, nestedMode, autoEoi}, 8'h02);
    wr(1'b1, 8'h77);
    chk("R6 mask", maskReg, 8'h77);
  endtask

  task automatic t_status();
    reqReg = 8'h81; isrReg = 8'h42;
    rd(1'b0);
    chk("R2 init selects request", rdData, 8'h81);
    wr(1'b0, 8'h0B);
    rd(1'b0);
    chk("R7 select isr", rdData, 8'h42);
    wr(1'b0, 8'h08);
    rd(1'b0);
    chk("R7 select kept", rdData, 8'h42);
    wr(1'b0, 8'h0A);
    rd(1'b0);
    chk("R7 select request", rdData, 8'h81);
    wr(1'b0, 8'h68);
    chk("R8 special mask set", {7'b0, specialMask}, 8'h01);
    wr(1'b0, 8'h28);
    chk("R8 special mask kept", {7'b0, specialMask}, 8'h01);
    wr(1'b0, 8'h48);
    chk("R8 special mask clear", {7'b0, specialMask}, 8'h00);
  endtask

  task automatic t_order();
    wr(1'b0, 8'h80);
    chk("R9 rotate set", {7'b0, rotateAutoEoi}, 8'h01);
    wr(1'b0, 8'h40);
    chk("R9 nop pulses", pulses(), 8'h00);
    chk("R9 nop rotate kept", {7'b0, rotateAutoEoi}, 8'h01);
    chk("R9 nop mask kept", maskReg, 8'h77);
    wr(1'b0, 8'h00);
    chk("R9 rotate clear", {7'b0, rotateAutoEoi}, 8'h00);
    wr(1'b0, 8'h20);
    chk("R10 nonspecific eoi", pulses(), 8'h10);
    wr(1'b0, 8'hA0);
    chk("R10 rotating eoi", pulses(), 8'h14);
    wr(1'b0, 8'h63);
    chk("R10 specific eoi", pulses(), 8'h18);
    chk("R10 specific line", {5'b0, eoiLine}, 8'h03);
    wr(1'b0, 8'hE5);
    chk("R10 specific rotating eoi", pulses(), 8'h1C);
    chk("R10 rotating line", {5'b0, eoiLine}, 8'h05);
    wr(1'b0, 8'hC6);
    chk("R11 set priority", pulses(), 8'h02);
    chk("R11 prio line", {5'b0, prioLine}, 8'h06);
  endtask

  task automatic t_poll();
    pollValid = 1'b1; pollLine = 3'd4;
    wr(1'b0, 8'h0C);
    rd(1'b1);
    chk("R12 poll data", rdData, 8'h84);
    chk("R12 poll ack", pulses(), 8'h01);
    chk("R12 ack line", {5'b0, ackLine}, 8'h04);
    rd(1'b1);
    chk("R12 disarmed plain read", rdData, 8'h77);
    chk("R12 no second ack", pulses(), 8'h00);
    pollValid = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b0);
    chk("R12 empty poll", rdData, 8'h00);
    chk("R12 empty no ack", pulses(), 8'h00);
    rd(1'b0);
    chk("R12 plain after empty poll", rdData, 8'h81);
  endtask

  task automatic t_trig();
    @(negedge clk); trigWrEn = 1'b1; trigData = 8'hFF;
    @(negedge clk); trigWrEn = 1'b0;
    chk("R13 trig masked", trigMode, 8'hF8);
    wr(1'b0, 8'h12);
    chk("R13 init leaves trig", trigMode, 8'hF8);
    wr(1'b1, 8'h00);
    @(negedge clk); trigWrEn = 1'b1; trigData = 8'h0F;
    @(negedge clk); trigWrEn = 1'b0;
    chk("R13 trig masked low", trigMode, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_single();
    t_init_full();
    t_init_level();
    t_restart();
    t_status();
    t_order();
    t_poll();
    t_trig();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule